// File: doc/BRIEF.md
# TDMA Normal Burst Formatter

This block turns one time slot of a TDMA transmitter into a serial bit stream. A one-clock start pulse, taken only while the block is idle, captures a 114-bit payload, a voice/data marker and a 26-bit training pattern. From then on the block emits one bit per bit strobe. Each burst is made of 148 active bits followed by a guard period, during which the transmitter is switched off.

The active bits appear in a fixed asymmetric order. First come three zero tail bits and the upper payload half. Next are a flag bit, the training midamble and a second flag bit. The lower payload half and three more zero tail bits close the active part. The guard period is nominally 8.25 bit periods. The block spreads the fraction over four slots: three slots get 8 guard bits and the fourth gets 9, so every four slots take exactly 625 bit periods. A busy output covers the whole slot, and a done pulse marks its end. The bit strobe is generated outside the block, as are modulation and channel coding.

Top module: `burst_serializer`

## Requirements
- R1: After reset the block is idle: busy, done, tx_en and tx_bit are all 0.
- R2: Burst positions 0..2 and 145..147 (position 0 is the first bit after start) carry logic 0 with tx_en high.
- R3: Positions 3..59 carry payload bits 113 down to 57, most significant first.
- R4: Positions 60 and 87 both carry the voice/data marker (is_data) as it was at the accepted start.
- R5: Positions 61..86 carry train_pat bits 25 down to 0, most significant first.
- R6: Positions 88..144 carry payload bits 56 down to 0, most significant first.
- R7: tx_en is high for exactly positions 0..147 and low in guard and idle. tx_bit is 0 whenever tx_en is low.
- R8: Counting slots from reset as 0,1,2,..., slot n has 9 guard bits when n mod 4 equals 3 and 8 guard bits otherwise.
- R9: A start pulse while busy is high has no effect. This includes a start in the same cycle as the last guard strobe. Input changes after an accepted start do not alter the burst.
- R10: On the clock edge that takes the last guard strobe, busy falls and done rises. done stays high for exactly one clock.
- R11: The burst position advances only on a clock where bit_en is high. Between strobes the output bit and tx_en hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit strobe, one clock wide, advances the burst by one bit |
| slot_start | input | 1 | Start of slot pulse, accepted only when idle |
| payload | input | 114 | Payload bits, captured at start |
| is_data | input | 1 | Voice (0) or data (1) marker, captured at start |
| train_pat | input | 26 | Training midamble pattern, captured at start |
| tx_bit | output | 1 | Serial output bit for the current position |
| tx_en | output | 1 | Transmit enable, high during the 148 active bits |
| busy | output | 1 | High from accepted start until the last guard strobe |
| done | output | 1 | One-clock pulse after the last guard strobe |

## Verification
Two events can fall on the same clock edge: the strobe that ends the slot and a new start pulse. The bench provokes this on purpose by raising slot_start together with the final guard strobe in some bursts. Because busy is still high on that edge, the start must be dropped. The bench judges this by seeing busy stay low and done fall on the following clock. A second provocation is a start pulse in the middle of the training field. After it, the same position must still be on the output and the rest of the burst must be unchanged.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [2:0] {
    SEG_TAIL,
    SEG_DATA_A,
    SEG_FLAG,
    SEG_TRAIN,
    SEG_DATA_B,
    SEG_GUARD
  } seg_e;

  // number of on-air bits in one burst
  function automatic int active_len(input int tail_w, input int data_w, input int train_w);
    return 2 * tail_w + 2 * data_w + train_w + 2;
  endfunction

  // guard length of the current slot: one extra bit on the long slot
  function automatic int guard_bits(input int gmin, input logic long_slot);
    return long_slot ? gmin + 1 : gmin;
  endfunction

  // which field a burst position belongs to
  function automatic seg_e seg_at(input int p, input int tail_w, input int data_w,
                                  input int train_w);
    int e_tail0, e_dat0, e_flg0, e_trn, e_flg1, e_dat1, e_tail1;
    e_tail0 = tail_w;
    e_dat0  = e_tail0 + data_w;
    e_flg0  = e_dat0 + 1;
    e_trn   = e_flg0 + train_w;
    e_flg1  = e_trn + 1;
    e_dat1  = e_flg1 + data_w;
    e_tail1 = e_dat1 + tail_w;
    if (p < e_tail0)      return SEG_TAIL;
    else if (p < e_dat0)  return SEG_DATA_A;
    else if (p < e_flg0)  return SEG_FLAG;
    else if (p < e_trn)   return SEG_TRAIN;
    else if (p < e_flg1)  return SEG_FLAG;
    else if (p < e_dat1)  return SEG_DATA_B;
    else if (p < e_tail1) return SEG_TAIL;
    else                  return SEG_GUARD;
  endfunction

endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ACTIVE_LEN = 148,
  parameter int GUARD_MIN  = 8,
  parameter int PHASE_W    = 2,
  parameter int POS_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               slot_start,
  output logic               busy,
  output logic               done,
  output logic [POS_W-1:0]   pos,
  output logic [PHASE_W-1:0] phase,
  output logic               accept
);
  import burst_pkg::*;

  logic               busy_q, done_q;
  logic [POS_W-1:0]   pos_q;
  logic [PHASE_W-1:0] phase_q;
  logic               long_slot;
  logic               final_bit;
  int                 last_idx;

  // the slot whose phase counter is all ones carries the extra guard bit
  assign long_slot = &phase_q;

  always_comb begin
    last_idx  = ACTIVE_LEN + guard_bits(GUARD_MIN, long_slot) - 1;
    final_bit = busy_q && bit_en && (int'(pos_q) == last_idx);
  end

  assign accept = slot_start && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pos_q   <= '0;
      phase_q <= '0;
    end else begin
      done_q <= final_bit;
      if (accept) begin
        busy_q <= 1'b1;
        pos_q  <= '0;
      end else if (final_bit) begin
        busy_q  <= 1'b0;
        pos_q   <= '0;
        phase_q <= phase_q + 1'b1;
      end else if (busy_q && bit_en) begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign pos   = pos_q;
  assign phase = phase_q;

endmodule

// File: rtl/burst_capture.sv
module burst_capture #(
  parameter int PAYLOAD_W = 114,
  parameter int TRAIN_W   = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [PAYLOAD_W-1:0] payload,
  input  logic                 is_data,
  input  logic [TRAIN_W-1:0]   train_pat,
  output logic [PAYLOAD_W-1:0] cap_payload,
  output logic                 cap_flag,
  output logic [TRAIN_W-1:0]   cap_train
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_payload <= '0;
      cap_flag    <= 1'b0;
      cap_train   <= '0;
    end else if (accept) begin
      cap_payload <= payload;
      cap_flag    <= is_data;
      cap_train   <= train_pat;
    end
  end

endmodule

// File: rtl/burst_bitmux.sv
module burst_bitmux #(
  parameter int TAIL_W  = 3,
  parameter int DATA_W  = 57,
  parameter int TRAIN_W = 26,
  parameter int POS_W   = 8
) (
  input  logic                  busy,
  input  logic [POS_W-1:0]      pos,
  input  logic [2*DATA_W-1:0]   cap_payload,
  input  logic                  cap_flag,
  input  logic [TRAIN_W-1:0]    cap_train,
  output burst_pkg::seg_e       seg,
  output logic                  tx_bit,
  output logic                  tx_en
);
  import burst_pkg::*;

  localparam int PL_IW    = $clog2(2 * DATA_W);
  localparam int TR_IW    = $clog2(TRAIN_W);
  localparam int TRN_BASE = TAIL_W + DATA_W + 1;
  localparam int DB_BASE  = TRN_BASE + TRAIN_W + 1;

  int   p;
  int   pl_i, tr_i;
  seg_e s;

  always_comb begin
    p    = int'(pos);
    s    = busy ? seg_at(p, TAIL_W, DATA_W, TRAIN_W) : SEG_GUARD;
    pl_i = 0;
    tr_i = 0;
    tx_bit = 1'b0;
    unique case (s)
      SEG_DATA_A: begin
        pl_i   = 2 * DATA_W - 1 - (p - TAIL_W);
        tx_bit = cap_payload[PL_IW'(pl_i)];
      end
      SEG_DATA_B: begin
        pl_i   = DATA_W - 1 - (p - DB_BASE);
        tx_bit = cap_payload[PL_IW'(pl_i)];
      end
      SEG_TRAIN: begin
        tr_i   = TRAIN_W - 1 - (p - TRN_BASE);
        tx_bit = cap_train[TR_IW'(tr_i)];
      end
      SEG_FLAG:  tx_bit = cap_flag;
      SEG_TAIL:  tx_bit = 1'b0;
      SEG_GUARD: tx_bit = 1'b0;
      default:   tx_bit = 1'b0;
    endcase
  end

  assign seg   = s;
  assign tx_en = (s != SEG_GUARD);

endmodule

// File: rtl/burst_serializer.sv
module burst_serializer #(
  parameter int TAIL_W    = 3,
  parameter int DATA_W    = 57,
  parameter int TRAIN_W   = 26,
  parameter int GUARD_MIN = 8,
  parameter int PHASE_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic                  slot_start,
  input  logic [2*DATA_W-1:0]   payload,
  input  logic                  is_data,
  input  logic [TRAIN_W-1:0]    train_pat,
  output logic                  tx_bit,
  output logic                  tx_en,
  output logic                  busy,
  output logic                  done
);
  import burst_pkg::*;

  localparam int PAYLOAD_W  = 2 * DATA_W;
  localparam int ACTIVE_LEN = active_len(TAIL_W, DATA_W, TRAIN_W);
  localparam int POS_W      = $clog2(ACTIVE_LEN + GUARD_MIN + 1);

  // internal events brought out for the checker
  logic [POS_W-1:0]     pos_w;
  logic [PHASE_W-1:0]   phase_w;
  logic                 accept_w;
  logic [PAYLOAD_W-1:0] cap_payload_w;
  logic                 cap_flag_w;
  logic [TRAIN_W-1:0]   cap_train_w;
  seg_e                 seg_w;

  burst_seq #(
    .ACTIVE_LEN (ACTIVE_LEN),
    .GUARD_MIN  (GUARD_MIN),
    .PHASE_W    (PHASE_W),
    .POS_W      (POS_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .slot_start (slot_start),
    .busy       (busy),
    .done       (done),
    .pos        (pos_w),
    .phase      (phase_w),
    .accept     (accept_w)
  );

  burst_capture #(
    .PAYLOAD_W (PAYLOAD_W),
    .TRAIN_W   (TRAIN_W)
  ) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept_w),
    .payload     (payload),
    .is_data     (is_data),
    .train_pat   (train_pat),
    .cap_payload (cap_payload_w),
    .cap_flag    (cap_flag_w),
    .cap_train   (cap_train_w)
  );

  burst_bitmux #(
    .TAIL_W  (TAIL_W),
    .DATA_W  (DATA_W),
    .TRAIN_W (TRAIN_W),
    .POS_W   (POS_W)
  ) u_mux (
    .busy        (busy),
    .pos         (pos_w),
    .cap_payload (cap_payload_w),
    .cap_flag    (cap_flag_w),
    .cap_train   (cap_train_w),
    .seg         (seg_w),
    .tx_bit      (tx_bit),
    .tx_en       (tx_en)
  );

endmodule

// File: rtl/burst_chk.sv
module burst_chk #(
  parameter int TAIL_W  = 3,
  parameter int POS_W   = 8,
  parameter int PHASE_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bit_en,
  input logic               slot_start,
  input logic               busy,
  input logic               done,
  input logic               tx_en,
  input logic               tx_bit,
  input logic [POS_W-1:0]   pos,
  input logic [PHASE_W-1:0] phase,
  input logic               cap_flag,
  input burst_pkg::seg_e    seg
);
  import burst_pkg::*;

  a_r7_en_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> busy);

  a_r7_guard_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_bit);

  a_r2_lead_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(pos) < TAIL_W) |-> (!tx_bit && tx_en));

  a_r4_flag_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_FLAG) |-> (tx_bit == cap_flag));

  a_r11_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en) |=> (busy && $stable(pos)));

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot_start && !bit_en) |=> $stable(pos));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == PHASE_W'($past(phase) + 1'b1)));

endmodule

bind burst_serializer burst_chk #(
  .TAIL_W  (TAIL_W),
  .POS_W   (POS_W),
  .PHASE_W (PHASE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .slot_start (slot_start),
  .busy       (busy),
  .done       (done),
  .tx_en      (tx_en),
  .tx_bit     (tx_bit),
  .pos        (pos_w),
  .phase      (phase_w),
  .cap_flag   (cap_flag_w),
  .seg        (seg_w)
);

// File: tb/test_burst_serializer.sv
`timescale 1ns/1ps
module test_burst_serializer;

  localparam int ACT = 148;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bit_en = 1'b0;
  logic         slot_start = 1'b0;
  logic [113:0] payload = '0;
  logic         is_data = 1'b0;
  logic [25:0]  train_pat = '0;
  logic         tx_bit, tx_en, busy, done;

  int checks = 0;
  int errors = 0;
  int slot_cnt = 0;
  int seed_sink;

  always #2 clk = ~clk;

  burst_serializer i_burst_serializer (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .slot_start (slot_start),
    .payload    (payload),
    .is_data    (is_data),
    .train_pat  (train_pat),
    .tx_bit     (tx_bit),
    .tx_en      (tx_en),
    .busy       (busy),
    .done       (done)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // expected on-air frame built as one vector, read from its top end
  function automatic logic [ACT-1:0] frame_of(input logic [113:0] pl, input logic f,
                                              input logic [25:0] tr);
    return {3'b000, pl[113:57], f, tr, f, pl[56:0], 3'b000};
  endfunction

  function automatic string tag_of(input int p);
    if (p >= ACT)  return "R7 guard";
    if (p < 3 || p >= 145) return "R2 tail";
    if (p < 60)    return "R3 data A";
    if (p == 60 || p == 87) return "R4 flag";
    if (p < 87)    return "R5 training";
    return "R6 data B";
  endfunction

  function automatic int guard_for(input int n);
    return (n % 4 == 3) ? 9 : 8;
  endfunction

  task automatic run_burst(input logic [113:0] pl, input logic f, input logic [25:0] tr,
                           input bit mid_start, input bit end_start);
    logic [ACT-1:0] fr;
    int glen;
    fr   = frame_of(pl, f, tr);
    glen = guard_for(slot_cnt);
    payload = pl; is_data = f; train_pat = tr; slot_start = 1'b1;
    @(posedge clk); @(negedge clk);
    slot_start = 1'b0;
    chk(busy === 1'b1, "R9 start accepted when idle", 32'(busy), 1);
    // scramble inputs: the captured copy must be used (R9)
    payload = ~pl; is_data = ~f; train_pat = ~tr;
    for (int p = 0; p < ACT + glen; p++) begin
      logic eb;
      eb = (p < ACT) ? fr[ACT-1-p] : 1'b0;
      chk(tx_bit === eb, tag_of(p), 32'(tx_bit), 32'(eb));
      chk(tx_en === (p < ACT), "R7 tx_en window", 32'(tx_en), 32'(p < ACT));
      chk(busy === 1'b1, "R8 busy through guard", 32'(busy), 1);
      if (mid_start && p == 70) begin
        slot_start = 1'b1;
        @(posedge clk); @(negedge clk);
        slot_start = 1'b0;
        chk(tx_bit === eb, "R9 R11 position kept after start while busy", 32'(tx_bit), 32'(eb));
      end
      bit_en = 1'b1;
      if (end_start && p == ACT + glen - 1) slot_start = 1'b1;
      @(posedge clk); @(negedge clk);
      bit_en = 1'b0; slot_start = 1'b0;
      if (p % 7 == 3) begin
        int gap;
        gap = int'($urandom % 3);
        for (int g = 0; g < gap; g++) @(negedge clk);
        if (p + 1 < ACT)
          chk(tx_bit === fr[ACT-2-p], "R11 hold between strobes", 32'(tx_bit),
              32'(fr[ACT-2-p]));
      end
    end
    chk(done === 1'b1, "R10 done after last guard strobe", 32'(done), 1);
    chk(busy === 1'b0, "R10 busy falls with done", 32'(busy), 0);
    @(negedge clk);
    chk(done === 1'b0, "R10 done one clock", 32'(done), 0);
    chk(busy === 1'b0, "R9 start with final strobe ignored", 32'(busy), 0);
    chk(tx_en === 1'b0, "R7 idle tx_en low", 32'(tx_en), 0);
    slot_cnt++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [113:0] pl;
    logic [25:0]  tr;
    logic         f;
    seed_sink = int'($urandom(32'h1a2b3c));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0, "R1 reset busy", 32'(busy), 0);
    chk(done === 1'b0, "R1 reset done", 32'(done), 0);
    chk(tx_en === 1'b0, "R1 reset tx_en", 32'(tx_en), 0);
    chk(tx_bit === 1'b0, "R1 reset tx_bit", 32'(tx_bit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // strobes while idle must not start anything (R11)
    bit_en = 1'b1; @(posedge clk); @(negedge clk); bit_en = 1'b0;
    chk(busy === 1'b0, "R11 idle strobe no effect", 32'(busy), 0);
    for (int b = 0; b < 13; b++) begin
      pl = 114'({$urandom, $urandom, $urandom, $urandom});
      tr = 26'($urandom);
      f  = 1'($urandom);
      if (b == 0) begin pl = '1; tr = '0; f = 1'b1; end
      if (b == 1) begin pl = '0; tr = '1; f = 1'b0; end
      if (b == 2) begin pl = {57'h0, {57{1'b1}}}; tr = 26'h2aaaaaa; f = 1'b1; end
      run_burst(pl, f, tr, (b % 3 == 1), (b % 4 == 2));
      for (int g = 0; g < int'($urandom % 4); g++) @(negedge clk);
    end
    summary();
  end

endmodule